// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Channel

This block is a single timer channel built on a pair of 8-bit count registers, a low byte and a high byte. A 4-bit configuration input selects one of four counting arrangements on that register pair: a 13-bit count with a 5-bit prescaler held in the low byte, a full 16-bit cascade, an 8-bit count that reloads itself from the high byte, and a hold mode that freezes both bytes. The same configuration input picks the count source and says whether an external gate pin takes part in run control.

The count source is either a tick from a divide-by-twelve of the system clock (timer use) or falling edges seen on an external event pin (counter use). In counter use the event pin is sampled once per divided-clock tick, so the event rate it can resolve is bounded by that tick rate. Software loads either byte through a write strobe, reads both bytes continuously, and clears a sticky overflow flag with a clear strobe.

Top module: `mtc_timer`

## Requirements
- R1: While rst_n is low at a clock edge, both count bytes and the overflow flag become 0 on that edge.
- R2: With cfg[2] = 0 the count source is one tick every 12 clock cycles, the first tick falling 12 cycles after reset is released, and each tick that is enabled advances the count by exactly one step.
- R3: With cfg[1:0] = 0, cnt_lo[4:0] counts modulo 32, each wrap of cnt_lo[4:0] adds one to cnt_hi, and cnt_lo[7:5] never change except by a software write.
- R4: With cfg[1:0] = 1, {cnt_hi, cnt_lo} counts as one 16-bit value, a carry out of the low byte adding one to the high byte.
- R5: With cfg[1:0] = 2, only cnt_lo counts; a step taken when cnt_lo is 8'hFF loads cnt_lo with cnt_hi, and cnt_hi is changed only by a software write.
- R6: With cfg[1:0] = 3, both bytes hold their value whatever run_en, the gate and the count source do.
- R7: With cfg[3] = 0, run_en alone enables counting; with cfg[3] = 1, counting also needs gate_pin high (gate_pin is taken as synchronous to clk).
- R8: With cfg[2] = 1, evt_pin passes through two synchronizing flops, its synchronized level is sampled on each divided-clock tick, and a step is taken on the tick whose sample is 0 when the previous tick's sample was 1.
- R9: ovf_flag is set on the step that wraps the 13-bit value (mode 0), the 16-bit value (mode 1) or the low byte (mode 2); it then stays set until flag_clr is high, and a set in the same cycle as flag_clr wins.
- R10: A write strobe (wr_lo or wr_hi) loads wr_data into its byte on the next edge, overriding any count or reload to that byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg | input | 4 | [1:0] mode, [2] event-pin source select, [3] gate enable |
| run_en | input | 1 | Software run control |
| gate_pin | input | 1 | External gate level, synchronous to clk |
| evt_pin | input | 1 | External event input, asynchronous |
| wr_lo | input | 1 | Load strobe for the low byte |
| wr_hi | input | 1 | Load strobe for the high byte |
| wr_data | input | 8 | Data for a byte load |
| flag_clr | input | 1 | Clears the overflow flag |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench aims at the wrap points: the 13-bit wrap with the low byte's top three bits set (a design that let the prescaler carry into bit 5 would corrupt them and miss the high-byte step), the 16-bit wrap, and the 8-bit reload, where taking the reload value from the wrong byte or disturbing the high byte shows at once. It writes a byte every cycle while counting so that writes land on count ticks, exposing a design where the increment beats the write. It toggles the gate pin and the event pin at rates around the tick period, so that a design that counts rising edges, skips synchronization or ignores the gate drifts from the reference, and it holds mode 3 with run high to catch a channel that keeps counting.

// File: rtl/mtc_pkg.sv
// Shared types for the multi-mode timer channel.
package mtc_pkg;
    typedef enum logic [1:0] {
        MD_PRE13   = 2'd0,
        MD_CAS16   = 2'd1,
        MD_RELOAD8 = 2'd2,
        MD_HOLD    = 2'd3
    } mtc_mode_e;
endpackage

// File: rtl/mtc_tick.sv
// Count-source generator. Divides clk by DIV to make a tick, and in event
// use synchronizes evt_pin, samples it on each tick and emits a one-cycle
// step on a 1-to-0 change between consecutive samples.
// Assumes: DIV >= 2, SYNC >= 2.
module mtc_tick #(
    parameter int DIV  = 12,
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic evt_pin,
    output logic step
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0]   pcnt;
    logic [SYNC-1:0] sync_q;
    logic            samp;
    logic            tick;
    logic            evt_s;

    assign tick  = (pcnt == LAST);
    assign evt_s = sync_q[SYNC-1];

    // Free-running divider that wraps after DIV cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + 1'b1;
    end

    // Synchronizer chain for the asynchronous event pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC-2:0], evt_pin};
    end

    // Sample of the synchronized event level, refreshed on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    samp <= 1'b0;
        else if (tick) samp <= evt_s;
    end

    // Select between the divided clock and detected falling events.
    always_comb begin
        if (ext_sel) step = tick & samp & ~evt_s;
        else         step = tick;
    end
endmodule

// File: rtl/mtc_core.sv
// Count register pair with mode-dependent next-state logic, byte writes
// and the sticky overflow flag. Assumes inc is already qualified by run
// control and is never high in hold mode.
module mtc_core
    import mtc_pkg::*;
#(
    parameter int W   = 8,
    parameter int PRE = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mtc_mode_e    mode,
    input  logic         inc,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wr_data,
    input  logic         flag_clr,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi,
    output logic         flag
);
    localparam logic [PRE-1:0] PMAX = '1;

    logic [W-1:0] nxt_lo;
    logic [W-1:0] nxt_hi;
    logic         wrap;
    logic [2*W:0] sum;

    assign sum = {1'b0, hi, lo} + {{(2*W){1'b0}}, 1'b1};

    // Next count per mode when a step is taken.
    always_comb begin
        nxt_lo = lo;
        nxt_hi = hi;
        wrap   = 1'b0;
        if (inc) begin
            case (mode)
                MD_PRE13: begin
                    if (lo[PRE-1:0] == PMAX) begin
                        nxt_lo[PRE-1:0] = '0;
                        nxt_hi          = hi + 1'b1;
                        wrap            = (hi == '1);
                    end else begin
                        nxt_lo[PRE-1:0] = lo[PRE-1:0] + 1'b1;
                    end
                end
                MD_CAS16: begin
                    nxt_lo = sum[W-1:0];
                    nxt_hi = sum[2*W-1:W];
                    wrap   = sum[2*W];
                end
                MD_RELOAD8: begin
                    if (lo == '1) begin
                        nxt_lo = hi;
                        wrap   = 1'b1;
                    end else begin
                        nxt_lo = lo + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Byte registers; a software write overrides the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= wr_lo ? wr_data : nxt_lo;
            hi <= wr_hi ? wr_data : nxt_hi;
        end
    end

    // Sticky overflow flag; a new overflow wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/mtc_timer.sv
// Top of the timer channel: decodes the configuration nibble, forms the
// run qualifier and joins the count source to the register pair.
// Assumes gate_pin is synchronous to clk; evt_pin may be asynchronous.
module mtc_timer
    import mtc_pkg::*;
#(
    parameter int W    = 8,
    parameter int PRE  = 5,
    parameter int DIV  = 12,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   cfg,
    input  logic         run_en,
    input  logic         gate_pin,
    input  logic         evt_pin,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W-1:0] wr_data,
    input  logic         flag_clr,
    output logic [W-1:0] cnt_lo,
    output logic [W-1:0] cnt_hi,
    output logic         ovf_flag
);
    mtc_mode_e mode;
    logic      ext_sel;
    logic      gate_en;
    logic      step;
    logic      inc;

    assign mode    = mtc_mode_e'(cfg[1:0]);
    assign ext_sel = cfg[2];
    assign gate_en = cfg[3];

    // A step counts only when running, gated if asked, and not held.
    assign inc = step & run_en & (~gate_en | gate_pin) & (mode != MD_HOLD);

    mtc_tick #(.DIV(DIV), .SYNC(SYNC)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (ext_sel),
        .evt_pin (evt_pin),
        .step    (step)
    );

    mtc_core #(.W(W), .PRE(PRE)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .inc      (inc),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wr_data  (wr_data),
        .flag_clr (flag_clr),
        .lo       (cnt_lo),
        .hi       (cnt_hi),
        .flag     (ovf_flag)
    );
endmodule

// File: rtl/mtc_timer_chk.sv
// Port-level property checker for mtc_timer, attached by bind.
module mtc_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   cfg,
    input logic         run_en,
    input logic         gate_pin,
    input logic         wr_lo,
    input logic         wr_hi,
    input logic [W-1:0] wr_data,
    input logic         flag_clr,
    input logic [W-1:0] cnt_lo,
    input logic [W-1:0] cnt_hi,
    input logic         ovf_flag
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt_lo == '0 && cnt_hi == '0 && !ovf_flag));

    assert_top_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[1:0] == 2'd0 && !wr_lo) |=> (cnt_lo[7:5] == $past(cnt_lo[7:5])));

    assert_reload_keeps_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[1:0] == 2'd2 && !wr_hi) |=> $stable(cnt_hi));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[1:0] == 2'd3 && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

    assert_gate_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[3] && !gate_pin && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    assert_write_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt_lo == $past(wr_data)));

    assert_write_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (cnt_hi == $past(wr_data)));
endmodule

bind mtc_timer mtc_timer_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .run_en   (run_en),
    .gate_pin (gate_pin),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .flag_clr (flag_clr),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .ovf_flag (ovf_flag)
);

// File: tb/sim_mtc_timer.sv
// Bench: behavioural reference model compared with the design every cycle.
module sim_mtc_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg = 4'd0;
    logic       run_en = 1'b0;
    logic       gate_pin = 1'b0;
    logic       evt_pin = 1'b0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       flag_clr = 1'b0;
    logic [7:0] cnt_lo;
    logic [7:0] cnt_hi;
    logic       ovf_flag;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference state
    int m_p = 0, m_s1 = 0, m_s2 = 0, m_samp = 0;
    int m_lo = 0, m_hi = 0, m_f = 0;

    always #10 clk = ~clk;

    mtc_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .run_en(run_en),
        .gate_pin(gate_pin), .evt_pin(evt_pin), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .flag_clr(flag_clr), .cnt_lo(cnt_lo),
        .cnt_hi(cnt_hi), .ovf_flag(ovf_flag)
    );

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        int tick, pulse, en, c, ovf, nlo, nhi;
        started = 1'b1;
        cycles++;
        if (!rst_n) begin
            m_p = 0; m_s1 = 0; m_s2 = 0; m_samp = 0;
            m_lo = 0; m_hi = 0; m_f = 0;
        end else begin
            tick  = (m_p == 11);
            pulse = cfg[2] ? (tick && m_samp == 1 && m_s2 == 0) : tick;
            en    = pulse && run_en && (!cfg[3] || gate_pin) && cfg[1:0] != 2'd3;
            nlo = m_lo; nhi = m_hi; ovf = 0;
            if (en) begin
                case (cfg[1:0])
                    2'd0: begin
                        c = m_hi * 32 + (m_lo % 32) + 1;
                        if (c == 8192) begin ovf = 1; c = 0; end
                        nlo = (m_lo / 32) * 32 + c % 32;
                        nhi = c / 32;
                    end
                    2'd1: begin
                        c = m_hi * 256 + m_lo + 1;
                        if (c == 65536) begin ovf = 1; c = 0; end
                        nlo = c % 256;
                        nhi = c / 256;
                    end
                    2'd2: begin
                        if (m_lo == 255) begin nlo = m_hi; ovf = 1; end
                        else nlo = m_lo + 1;
                    end
                    default: ;
                endcase
            end
            if (wr_lo) nlo = wr_data;
            if (wr_hi) nhi = wr_data;
            if (ovf) m_f = 1;
            else if (flag_clr) m_f = 0;
            m_lo = nlo; m_hi = nhi;
            if (tick) m_samp = m_s2;
            m_s2 = m_s1;
            m_s1 = evt_pin;
            m_p = tick ? 0 : m_p + 1;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            n_vec++;
            if (cnt_lo !== 8'(m_lo) || cnt_hi !== 8'(m_hi) || ovf_flag !== (m_f != 0)) begin
                n_bad++;
                $display("FAIL %s cycle %0d: lo/hi/flag actual %h/%h/%b expected %h/%h/%0d",
                         cur_req, cycles, cnt_lo, cnt_hi, ovf_flag, 8'(m_lo), 8'(m_hi), m_f);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wbyte(input bit hi, input logic [7:0] d);
        @(negedge clk);
        wr_lo = !hi; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b0;
    endtask

    task automatic pulse_clr;
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        cur_req = "R1";
        idle(4);
        rst_n = 1'b1;
        // R2 and R4: 16-bit timer from the divided clock, near wrap
        cur_req = "R4";
        cfg = 4'b0001;
        wbyte(1'b1, 8'hFF);
        wbyte(1'b0, 8'hF0);
        run_en = 1'b1;
        cur_req = "R2";
        idle(12 * 20);
        // R9: flag sticky, then cleared
        cur_req = "R9";
        idle(30);
        pulse_clr();
        idle(20);
        // R10: writes every cycle while counting collide with ticks
        cur_req = "R10";
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            wr_lo = 1'b1; wr_hi = (i % 3 == 0); wr_data = 8'(i * 7);
        end
        @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b0;
        idle(30);
        // R3: 13-bit mode with top bits of the low byte set
        cur_req = "R3";
        cfg = 4'b0000;
        wbyte(1'b1, 8'hFF);
        wbyte(1'b0, 8'hFC);
        idle(12 * 40);
        pulse_clr();
        // R5: reload from the high byte
        cur_req = "R5";
        cfg = 4'b0010;
        wbyte(1'b1, 8'h80);
        wbyte(1'b0, 8'hFD);
        idle(12 * 300);
        // R9: overflow in the same cycle as a clear; clear held high
        cur_req = "R9";
        flag_clr = 1'b1;
        idle(12 * 140);
        flag_clr = 1'b0;
        // R6: hold mode with run high
        cur_req = "R6";
        cfg = 4'b0011;
        idle(200);
        // R7: gate enabled, gate pin toggled
        cur_req = "R7";
        cfg = 4'b1001;
        wbyte(1'b1, 8'h00);
        wbyte(1'b0, 8'h00);
        for (int i = 0; i < 30; i++) begin
            gate_pin = (i % 3 != 0);
            idle(7 + (i % 5) * 4);
        end
        gate_pin = 1'b0;
        cfg = 4'b0001;
        idle(12 * 6);
        run_en = 1'b0;
        idle(12 * 3);
        run_en = 1'b1;
        // R8: event counting at several toggle rates
        cur_req = "R8";
        cfg = 4'b0101;
        for (int i = 0; i < 20; i++) begin
            evt_pin = ~evt_pin; idle(30);
        end
        for (int i = 0; i < 40; i++) begin
            evt_pin = ~evt_pin; idle(7);
        end
        for (int i = 0; i < 40; i++) begin
            evt_pin = ~evt_pin; idle(3);
        end
        evt_pin = 1'b0;
        idle(40);
        // R1: reset mid-count
        cur_req = "R1";
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(20);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule